// File: doc/BRIEF.md
# Overlapping 101/1001 Serial Pattern Detector

This block watches a serial bit stream, one bit per rising clock edge, and raises a match flag whenever the bits accepted since the last reset end in either `101` or `1001`. Both patterns are tracked by a single four-state machine. A detection never returns the machine to its start state, so a pattern that shares bits with the previous one is still reported.

The match flag is a Mealy output. It is decoded from the current state and the bit currently on the input, so it goes high in the same cycle in which the final `1` of a pattern is presented. A synchronous, active-high reset puts the machine in its start state. Bits presented while reset is high are discarded.

The four states are:
- `S_IDLE`: the start state, with no useful suffix.
- `S_GOT1`: the last bit was `1`.
- `S_GOT10`: the last bits were `10`.
- `S_GOT100`: the last bits were `100`.

The transitions are:
- IDLE: a 1 goes to GOT1 and a 0 stays in IDLE.
- GOT1: a 1 stays in GOT1 and a 0 goes to GOT10.
- GOT10: a 1 flags a match and goes to GOT1, and a 0 goes to GOT100.
- GOT100: a 1 flags a match and goes to GOT1, and a 0 returns to IDLE.

Top module: `sqd_detector`

## Requirements
- R1: `match` is 1 in the cycle whose `bit_in` completes a `101` suffix of the bits accepted since reset.
- R2: `match` is 1 in the cycle whose `bit_in` completes a `1001` suffix of the bits accepted since reset.
- R3: `match` is 0 in every other cycle. This covers runs of ones, `10001`, and suffixes that need bits accepted before the last reset.
- R4: Matches overlap. `10101` flags on bits 3 and 5, and `1001001` flags on bits 4 and 7. After a match the machine is in GOT1, never IDLE.
- R5: While `rst` is high at a rising edge, the state becomes IDLE and the bit is discarded. `match` is 0 whenever `rst` is high.
- R6: After reset, the input `110100110010110` gives `match` = `000100100010100`, bit for bit in time order (leftmost first).
- R7: Every state behaves as the transition list above for both input values, over long random streams.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock; one stream bit per edge |
| rst | input | 1 | Synchronous active-high reset to IDLE |
| bit_in | input | 1 | Serial stream bit |
| match | output | 1 | Mealy flag: history plus current bit ends in 101 or 1001 |

## Verification
The bench goes after the following corner cases:
- **Overlap.** Back-to-back chains such as `10101` and `1001001` are driven. A design that returned to IDLE after a hit would miss the second flag.
- **Three zeros.** The run `10001` is driven. A design that forgot to leave GOT100 on a third zero would raise a false flag.
- **Reset in mid-pattern.** Reset is applied partway through a pattern. A design that kept old history, or flagged while in reset, would show a spurious match.
- **Registered output.** Every check samples `match` in the cycle of the final bit. An output that was registered would show up one cycle late.

Long random streams are compared with a suffix model. This reaches every state under both input values.

// File: rtl/sqd_pkg.sv
package sqd_pkg;
    localparam int STATE_W = 2;

    typedef enum logic [STATE_W-1:0] {
        S_IDLE   = 2'd0,
        S_GOT1   = 2'd1,
        S_GOT10  = 2'd2,
        S_GOT100 = 2'd3
    } sqd_state_e;
endpackage

// File: rtl/sqd_next.sv
module sqd_next
    import sqd_pkg::*;
(
    input  sqd_state_e cur,
    input  logic       bit_in,
    output sqd_state_e nxt
);
    always_comb begin
        nxt = S_IDLE;
        unique case (cur)
            S_IDLE:   nxt = bit_in ? S_GOT1 : S_IDLE;
            S_GOT1:   nxt = bit_in ? S_GOT1 : S_GOT10;
            S_GOT10:  nxt = bit_in ? S_GOT1 : S_GOT100;
            S_GOT100: nxt = bit_in ? S_GOT1 : S_IDLE;
            default:  nxt = S_IDLE;
        endcase
    end
endmodule

// File: rtl/sqd_out.sv
module sqd_out
    import sqd_pkg::*;
(
    input  sqd_state_e cur,
    input  logic       rst,
    input  logic       bit_in,
    output logic       match
);
    logic armed;

    always_comb begin
        armed = 1'b0;
        unique case (cur)
            S_IDLE:   armed = 1'b0;
            S_GOT1:   armed = 1'b0;
            S_GOT10:  armed = 1'b1;
            S_GOT100: armed = 1'b1;
            default:  armed = 1'b0;
        endcase
        match = armed & bit_in & ~rst;
    end
endmodule

// File: rtl/sqd_detector.sv
module sqd_detector
    import sqd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bit_in,
    output logic match
);
    sqd_state_e state_q;
    sqd_state_e state_d;

    sqd_next u_next (
        .cur    (state_q),
        .bit_in (bit_in),
        .nxt    (state_d)
    );

    sqd_out u_out (
        .cur    (state_q),
        .rst    (rst),
        .bit_in (bit_in),
        .match  (match)
    );

    always_ff @(posedge clk) begin
        if (rst) state_q <= S_IDLE;
        else     state_q <= state_d;
    end
endmodule

// File: rtl/sqd_checker.sv
module sqd_checker
    import sqd_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       x,
    input logic       z,
    input sqd_state_e state
);
    // number of bits accepted since reset, saturating at 3
    logic [1:0] seen;

    always_ff @(posedge clk) begin
        if (rst)               seen <= 2'd0;
        else if (seen != 2'd3) seen <= seen + 2'd1;
    end

    assert_reset_start_R5: assert property (@(posedge clk)
        rst |=> (state == S_IDLE));

    assert_quiet_in_reset_R5: assert property (@(posedge clk)
        rst |-> !z);

    assert_hit_101_R1: assert property (@(posedge clk) disable iff (rst)
        (seen >= 2'd2 && x && !$past(x) && $past(x, 2)) |-> z);

    assert_hit_1001_R2: assert property (@(posedge clk) disable iff (rst)
        (seen == 2'd3 && x && !$past(x) && !$past(x, 2) && $past(x, 3)) |-> z);

    assert_no_false_hit_R3: assert property (@(posedge clk) disable iff (rst)
        z |-> (x && seen >= 2'd2 && !$past(x) &&
               ($past(x, 2) || (seen == 2'd3 && $past(x, 3)))));

    assert_overlap_keeps_one_R4: assert property (@(posedge clk) disable iff (rst)
        z |=> (state == S_GOT1));
endmodule

bind sqd_detector sqd_checker u_chk (
    .clk   (clk),
    .rst   (rst),
    .x     (bit_in),
    .z     (match),
    .state (state_q)
);

// File: tb/tb_sqd_detector.sv
`timescale 1ns/1ps
module tb_sqd_detector;
    typedef struct {
        logic  exp;
        string req;
    } item_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_in = 1'b0;
    logic match;

    item_t sb_q[$];
    int checks = 0;
    int failures = 0;
    logic [3:0] hist = 4'd0;
    int n_seen = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sqd_detector dut (
        .clk    (clk),
        .rst    (rst),
        .bit_in (bit_in),
        .match  (match)
    );

    // monitor: compare each pushed expectation against the Mealy output
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                checks++;
                if (match !== it.exp) begin
                    failures++;
                    $display("FAIL %s: match=%0b expected=%0b at %0t",
                             it.req, match, it.exp, $time);
                end
            end
        end
    end

    function automatic logic model_next(logic b);
        logic e;
        hist = {hist[2:0], b};
        e = (n_seen >= 2 && hist[2:0] == 3'b101) ||
            (n_seen >= 3 && hist == 4'b1001);
        if (n_seen < 3) n_seen++;
        return e;
    endfunction

    task automatic send_bit(logic b, string req);
        item_t it;
        @(negedge clk);
        rst = 1'b0;
        bit_in = b;
        it.exp = model_next(b);
        it.req = req;
        sb_q.push_back(it);
    endtask

    task automatic send_exp(logic b, logic e, string req);
        item_t it;
        @(negedge clk);
        rst = 1'b0;
        bit_in = b;
        void'(model_next(b));
        it.exp = e;
        it.req = req;
        sb_q.push_back(it);
    endtask

    task automatic do_reset(int cycles);
        for (int i = 0; i < cycles; i++) begin
            item_t it;
            @(negedge clk);
            rst = 1'b1;
            bit_in = $urandom_range(0, 1);
            it.exp = 1'b0;
            it.req = "R5 quiet during reset";
            sb_q.push_back(it);
        end
        hist = 4'd0;
        n_seen = 0;
    endtask

    task automatic send_str(string s, string req);
        for (int i = 0; i < s.len(); i++)
            send_bit(s[i] == "1", req);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        string xs;
        string zs;
        xs = "110100110010110";
        zs = "000100100010100";
        do_reset(2);

        // R6: fixed reference vector against a literal expected output
        for (int i = 0; i < xs.len(); i++)
            send_exp(xs[i] == "1", zs[i] == "1", "R6 reference vector");

        // R1 plain 101, R2 plain 1001
        do_reset(1);
        send_str("101", "R1 101 suffix");
        do_reset(1);
        send_str("1001", "R2 1001 suffix");

        // R3: runs of ones and a triple zero give no hit
        do_reset(1);
        send_str("111110001", "R3 no false hit");

        // R4: overlapping chains
        do_reset(1);
        send_str("10101", "R4 overlap 10101");
        do_reset(1);
        send_str("1001001", "R4 overlap 1001001");

        // R5: history before reset must not combine with bits after it
        do_reset(1);
        send_str("10", "R5 pre-reset prefix");
        do_reset(1);
        send_str("1", "R5 no carried history");
        send_str("10", "R5 pre-reset prefix");
        do_reset(3);
        send_str("01", "R5 no carried history");

        // R7: long random streams with occasional resets
        for (int blk = 0; blk < 8; blk++) begin
            do_reset(1);
            for (int i = 0; i < 500; i++)
                send_bit($urandom_range(0, 1), "R7 random stream");
        end

        while (sb_q.size() > 0) @(negedge clk);
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule